// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits between an interrupt router and a processor core. The router delivers messages. Each message carries an 8-bit vector and a flag that says whether the source is level-sensitive. The controller latches every message in a 256-bit pending register. It asserts a single interrupt line to the core when the best pending vector clears two gates. The first gate is a software task-priority value. The second gate is the vector currently being serviced. A higher vector number means a higher priority. Both gates compare the priority class, which is the top four bits of the vector.

The core takes an interrupt by pulsing an acknowledge input. The winning vector is shown on `ack_vec_o`, and the acknowledge moves it from pending to in-service. When the handler finishes, the core pulses end-of-interrupt. This retires the highest in-service vector. If that vector arrived as level-sensitive, the controller sends a one-cycle message naming it back to the router, so the router can sample the source line again. The task-priority value has a plain write port, which lets software mask classes at or below a chosen level.

Top module: `vec_intc`

## Requirements
- R1: A message sets the pending bit of its vector. It also writes the vector's trigger-mode bit: 1 when `msg_level_i` is 1, and 0 when it is 0. The latest message for a vector decides that vector's bit.
- R2: `irq_o` is registered. A message accepted at one rising edge can raise `irq_o` no earlier than the next rising edge.
- R3: Vector priority follows the numeric value, so higher is better. `ack_vec_o` always shows the highest-numbered pending vector.
- R4: A pending vector can interrupt only if its class (bits [7:4]) is strictly greater than the class of the task-priority value. A vector that fails this test stays pending.
- R5: When any vector is in service, a pending vector can interrupt only if its class is strictly greater than the class of the highest in-service vector.
- R6: An acknowledge while `irq_o` is 1 does three things: it clears the pending bit of the `ack_vec_o` vector, sets that vector's in-service bit, and forces `irq_o` to 0 for the next cycle. An acknowledge while `irq_o` is 0 has no effect.
- R7: An end-of-interrupt clears both the in-service bit and the pending bit of the highest-numbered in-service vector. An end-of-interrupt with no vector in service has no effect.
- R8: When the retired vector's trigger-mode bit is 1, `eoi_msg_valid_o` is 1 for exactly one cycle, starting at the edge after the end-of-interrupt, and `eoi_msg_vec_o` names that vector. When the bit is 0, no message is sent.
- R9: A task-priority write is captured at one edge and changes `irq_o` at the following edge.
- R10: After reset, every pending, in-service and trigger-mode bit is 0, the task priority is 0, `irq_o` is 0 and `eoi_msg_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Incoming interrupt message strobe |
| msg_vec_i | input | 8 | Vector of the incoming message |
| msg_level_i | input | 1 | 1 = level-sensitive source, 0 = edge |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority write value |
| irq_o | output | 1 | Interrupt request to the core |
| ack_i | input | 1 | Core acknowledge |
| ack_vec_o | output | 8 | Highest pending vector, taken by the acknowledge |
| eoi_i | input | 1 | Core end-of-interrupt |
| eoi_msg_valid_o | output | 1 | End-of-interrupt message strobe to the router |
| eoi_msg_vec_o | output | 8 | Vector named in that message |

## Verification
The bench builds the block with its default parameters: 8-bit vectors and 4-bit classes, which gives the full 256-vector space and 16 classes. This makes same-class pairs such as 0x52 and 0x58 reachable, where the in-service gate must hold back a pending vector. It also makes the three-vector sequence 0xA1, 0x93, 0x71 reachable, which exercises nested retirement order. Some boundary cases are driven at the ports: a class equal to the task-priority class, an acknowledge with the line low, an end-of-interrupt with nothing in service, and a vector re-posted while it is in service.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int unsigned VEC_W_DEF = 8;
  localparam int unsigned CLS_W_DEF = 4;
endpackage

// File: rtl/vec_intc_top_bit.sv
module vec_intc_top_bit #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |vec_i;

  // last hit wins, so the highest set bit is reported
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vec_intc_gate.sv
module vec_intc_gate #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CLS_W = 4
) (
  input  logic             req_any_i,
  input  logic [VEC_W-1:0] req_top_i,
  input  logic             svc_any_i,
  input  logic [VEC_W-1:0] svc_top_i,
  input  logic [VEC_W-1:0] tpr_i,
  output logic             fire_o
);
  logic [CLS_W-1:0] req_cls, svc_cls, tpr_cls;

  assign req_cls = req_top_i[VEC_W-1 -: CLS_W];
  assign svc_cls = svc_top_i[VEC_W-1 -: CLS_W];
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];

  assign fire_o = req_any_i && (req_cls > tpr_cls) &&
                  (!svc_any_i || (req_cls > svc_cls));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int unsigned VEC_W = VEC_W_DEF,
  parameter int unsigned CLS_W = CLS_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_valid_i,
  input  logic [VEC_W-1:0] msg_vec_i,
  input  logic             msg_level_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  output logic             irq_o,
  input  logic             ack_i,
  output logic [VEC_W-1:0] ack_vec_o,
  input  logic             eoi_i,
  output logic             eoi_msg_valid_o,
  output logic [VEC_W-1:0] eoi_msg_vec_o
);
  localparam int unsigned NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] irr_q, irr_d, isr_q, isr_d, tmr_q, tmr_d;
  logic [VEC_W-1:0]   tpr_q;
  logic               irq_q, eoi_vld_q;
  logic [VEC_W-1:0]   eoi_vec_q;

  logic               irr_any, isr_any, dispatch;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic               ack_fire, eoi_fire;

  vec_intc_top_bit #(.W(NUM_VEC), .IDX_W(VEC_W)) u_irr_top (
    .vec_i(irr_q), .any_o(irr_any), .idx_o(irr_top)
  );

  vec_intc_top_bit #(.W(NUM_VEC), .IDX_W(VEC_W)) u_isr_top (
    .vec_i(isr_q), .any_o(isr_any), .idx_o(isr_top)
  );

  vec_intc_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_gate (
    .req_any_i(irr_any), .req_top_i(irr_top),
    .svc_any_i(isr_any), .svc_top_i(isr_top),
    .tpr_i(tpr_q), .fire_o(dispatch)
  );

  assign ack_fire = ack_i & irq_q;
  assign eoi_fire = eoi_i & isr_any;

  // clears first, a same-cycle message set wins
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_fire) begin
      irr_d[irr_top] = 1'b0;
      isr_d[irr_top] = 1'b1;
    end
    if (eoi_fire) begin
      isr_d[isr_top] = 1'b0;
      irr_d[isr_top] = 1'b0;
    end
    if (msg_valid_i) begin
      irr_d[msg_vec_i] = 1'b1;
      tmr_d[msg_vec_i] = msg_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tmr_q     <= '0;
      tpr_q     <= '0;
      irq_q     <= 1'b0;
      eoi_vld_q <= 1'b0;
      eoi_vec_q <= '0;
    end else begin
      irr_q     <= irr_d;
      isr_q     <= isr_d;
      tmr_q     <= tmr_d;
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      irq_q     <= dispatch & ~ack_fire;
      eoi_vld_q <= eoi_fire & tmr_q[isr_top];
      eoi_vec_q <= isr_top;
    end
  end

  assign irq_o           = irq_q;
  assign ack_vec_o       = irr_top;
  assign eoi_msg_valid_o = eoi_vld_q;
  assign eoi_msg_vec_o   = eoi_vec_q;
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned NUM_VEC = 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_i,
  input logic [VEC_W-1:0]   msg_vec_i,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   ack_vec_o,
  input logic               eoi_msg_valid_o,
  input logic [NUM_VEC-1:0] irr_i,
  input logic [NUM_VEC-1:0] isr_i
);
  assert_msg_latched_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |=> irr_i[$past(msg_vec_i)]);

  assert_irq_needs_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|irr_i));

  assert_ack_drops_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !irq_o);

  assert_ack_sets_service_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !eoi_i) |=> isr_i[$past(ack_vec_o)]);

  assert_empty_eoi_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(|isr_i)) |=> !eoi_msg_valid_o);

  assert_eoi_msg_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_msg_valid_o |-> $past(eoi_i));
endmodule

bind vec_intc vec_intc_chk #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_i(msg_valid_i), .msg_vec_i(msg_vec_i),
  .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o), .ack_vec_o(ack_vec_o),
  .eoi_msg_valid_o(eoi_msg_valid_o), .irr_i(irr_q), .isr_i(isr_q)
);

// File: tb/vec_intc_test.sv
module vec_intc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_valid = 1'b0, msg_level = 1'b0;
  logic [7:0] msg_vec = '0;
  logic       tpr_we = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic       ack = 1'b0, eoi = 1'b0;
  logic       irq, eoi_vld;
  logic [7:0] ack_vec, eoi_vec;

  int n_chk = 0, n_fail = 0;
  logic [7:0] eoi_q[$];

  always #10 clk = ~clk;

  vec_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(msg_valid), .msg_vec_i(msg_vec),
    .msg_level_i(msg_level), .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
    .irq_o(irq), .ack_i(ack), .ack_vec_o(ack_vec), .eoi_i(eoi),
    .eoi_msg_valid_o(eoi_vld), .eoi_msg_vec_o(eoi_vec)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares router messages against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && eoi_vld) begin
      if (eoi_q.size() == 0) chk(1'b0, "R8", "unexpected eoi message", eoi_vec, 0);
      else begin
        automatic logic [7:0] e = eoi_q.pop_front();
        chk(eoi_vec == e, "R8", "eoi message vector", eoi_vec, e);
      end
    end
  end

  task automatic send(input logic [7:0] v, input logic lvl);
    msg_valid = 1'b1; msg_vec = v; msg_level = lvl;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic write_tpr(input logic [7:0] v);
    tpr_we = 1'b1; tpr_wdata = v;
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk(!seen, req, "irq held low", seen, 0);
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(irq, req, "irq raised", irq, 1);
  endtask

  task automatic do_ack(input logic [7:0] exp);
    chk(irq, "R6", "irq before ack", irq, 1);
    chk(ack_vec == exp, "R3", "ack vector", ack_vec, exp);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(!irq, "R6", "irq dropped after ack", irq, 0);
  endtask

  task automatic do_eoi(input logic [7:0] v, input logic lvl);
    if (lvl) eoi_q.push_back(v);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk(eoi_vld == lvl, "R8", "eoi message strobe", eoi_vld, lvl);
    @(negedge clk);
    chk(!eoi_vld, "R8", "eoi message one cycle", eoi_vld, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!irq, "R10", "irq after reset", irq, 0);
    chk(!eoi_vld, "R10", "eoi msg after reset", eoi_vld, 0);
    chk(ack_vec == 8'h00, "R10", "no pending after reset", ack_vec, 0);

    // R2 latency, single edge vector
    send(8'h45, 1'b0);
    chk(!irq, "R2", "irq not yet", irq, 0);
    @(negedge clk);
    chk(irq, "R2", "irq one edge later", irq, 1);
    do_ack(8'h45);
    quiet(3, "R6");
    do_eoi(8'h45, 1'b0);

    // R4 task-priority gate, R9 write timing
    write_tpr(8'h50);
    send(8'h52, 1'b0);
    quiet(4, "R4");
    write_tpr(8'h40);
    chk(!irq, "R9", "tpr not yet effective", irq, 0);
    @(negedge clk);
    chk(irq, "R9", "tpr effective", irq, 1);
    do_ack(8'h52);
    // R5 in-service gate
    send(8'h58, 1'b0);
    quiet(4, "R5");
    send(8'h61, 1'b1);
    wait_irq("R5");
    do_ack(8'h61);
    do_eoi(8'h61, 1'b1);        // R7 highest in-service retired first
    quiet(4, "R5");
    do_eoi(8'h52, 1'b0);
    wait_irq("R5");
    do_ack(8'h58);
    do_eoi(8'h58, 1'b0);
    write_tpr(8'h00);

    // R6 acknowledge with line low ignored
    write_tpr(8'h30);
    send(8'h30, 1'b0);
    quiet(3, "R4");
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    quiet(2, "R6");
    write_tpr(8'h00);
    wait_irq("R6");
    do_ack(8'h30);
    do_eoi(8'h30, 1'b0);

    // R7 eoi with nothing in service ignored
    write_tpr(8'hF0);
    send(8'h24, 1'b1);
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    @(negedge clk);
    chk(!eoi_vld, "R7", "empty eoi no message", eoi_vld, 0);
    write_tpr(8'h00);
    wait_irq("R7");
    do_ack(8'h24);
    do_eoi(8'h24, 1'b1);

    // R3 nested ordering of three level vectors
    send(8'hA1, 1'b1);
    send(8'h71, 1'b1);
    send(8'h93, 1'b1);
    wait_irq("R3");
    do_ack(8'hA1);
    quiet(3, "R5");
    do_eoi(8'hA1, 1'b1);
    wait_irq("R3");
    do_ack(8'h93);
    do_eoi(8'h93, 1'b1);
    wait_irq("R3");
    do_ack(8'h71);
    do_eoi(8'h71, 1'b1);

    // R1 a later edge message overrides the level flag
    send(8'h85, 1'b1);
    send(8'h85, 1'b0);
    wait_irq("R1");
    do_ack(8'h85);
    do_eoi(8'h85, 1'b0);

    // R7 eoi clears a re-posted pending bit of the retired vector
    send(8'h90, 1'b1);
    wait_irq("R7");
    do_ack(8'h90);
    send(8'h90, 1'b1);
    quiet(3, "R5");
    do_eoi(8'h90, 1'b1);
    quiet(4, "R7");
    chk(ack_vec == 8'h00, "R7", "pending cleared by eoi", ack_vec, 0);

    repeat (2) @(negedge clk);
    chk(eoi_q.size() == 0, "R8", "all eoi messages seen", eoi_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule